// File: doc/BRIEF.md
# Daisy-Chained Peripheral Bus Requester

This block sits on a peripheral card and wins single memory cycles on a shared memory bus with a 16-bit address and 8-bit data. A memory cycle is framed by the three bus clock phases. It starts at one falling edge of the third phase and ends at the next one. Three claimants outrank every peripheral. In falling order they are the CPU, memory refresh and character refresh. Peripherals then share what is left through a daisy chain: a request arriving from an upstream card wins over this card and is passed on downstream.

A local client hands the block one transaction at a time: a read or a write, an address and write data. The block waits for a free cycle. In that cycle it drives the address and one strobe, and the write data for a write, for the whole cycle. For a read it captures the returned byte, then reports completion with a one-clock pulse. The bus lines are ground-true and open-collector. Each driven line is therefore modelled as a drive enable plus a level, and the level is the inverse of the logical value. The phases and the claim lines are brought into the fast system clock domain through a synchronizer.

Top module: `chain_bus_requester`

## Requirements
- R1: While reset is held, the block drives no bus line, every output level reads high, `req_ready` is 1 and `done` is 0.
- R2: The decision to own a memory cycle is taken only at the falling edge of the third clock phase that opens the cycle. Ownership ends at the next such edge. One accepted request uses exactly one cycle.
- R3: If the CPU, memory-refresh or character-refresh claim is asserted at the opening edge, the block does not take that cycle, whatever the rest of the claims and the chain say.
- R4: If the upstream chain request is asserted at the opening edge, the block does not take the cycle. While the upstream request is asserted, the downstream chain output is asserted as well (pass-through).
- R5: Throughout an owned cycle the block asserts its downstream chain output, even when the upstream input is idle.
- R6: In an owned cycle the address and exactly one strobe are driven unchanged for the whole cycle: the read strobe for reads and the write strobe for writes. Write data is driven for the whole cycle of a write and never during a read.
- R7: For a read, the data byte is captured at the first falling edge of the second clock phase that follows a first-phase rising edge inside the owned cycle. It is returned on `done_rdata` with the done pulse.
- R8: All bus signals are ground-true. A driven line carries the inverse of its logical value (logical 1 = level 0). A released line has drive enable 0 and level 1.
- R9: A pending request survives any run of blocked cycles, including 80 consecutive character-refresh cycles. It is then served in the first free cycle.
- R10: `done` is a one-clock pulse issued as the owned cycle closes. `req_ready` is 0 from acceptance until that pulse, and a request offered while `req_ready` is 0 is dropped and has no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phi1 | input | 1 | Bus clock phase 1 |
| phi2 | input | 1 | Bus clock phase 2 |
| phi3 | input | 1 | Bus clock phase 3 |
| cpu_claim_l | input | 1 | CPU bus claim, bus level (low = asserted) |
| mref_claim_l | input | 1 | Memory refresh claim, bus level |
| cref_claim_l | input | 1 | Character refresh claim, bus level |
| chain_in_l | input | 1 | Upstream peripheral request, bus level |
| chain_out_oe | output | 1 | Drive enable of downstream request |
| chain_out_lvl | output | 1 | Level of downstream request |
| addr_oe | output | 1 | Drive enable of address lines |
| addr_lvl | output | 16 | Address line levels |
| rd_oe | output | 1 | Drive enable of read strobe |
| rd_lvl | output | 1 | Read strobe level |
| wr_oe | output | 1 | Drive enable of write strobe |
| wr_lvl | output | 1 | Write strobe level |
| data_in_lvl | input | 8 | Data line levels seen on the bus |
| data_oe | output | 1 | Drive enable of data lines |
| data_out_lvl | output | 8 | Data line levels driven for a write |
| req_valid | input | 1 | Local request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Local request address |
| req_wdata | input | 8 | Local write data |
| req_ready | output | 1 | Block idle, can accept a request |
| done | output | 1 | One-clock completion pulse |
| done_rdata | output | 8 | Read data, valid with `done` |

## Verification
On every clock the assertions check several properties. Ownership may only start or stop on a detected opening edge. No higher claim or upstream request was present when ownership started. The chain output covers both the pass-through and the owned cycle. Exactly one strobe is driven and the address stays stable while owned, released lines read high, and `done` is a single pulse that closes ownership. Other behaviour needs the bench's scenarios: which cycle a pending request finally lands in after a mixed run of claims or an 80-cycle refresh burst, the byte actually captured at the second-phase edge, and proof that a request offered while busy never reaches the bus.

// File: rtl/cbr_pkg.sv
// Shared constants for the chained bus requester.
// Assumes: the bus geometry is fixed at 16 address and 8 data bits by default.
package cbr_pkg;
    parameter int unsigned CBR_ADDR_W = 16;
    parameter int unsigned CBR_DATA_W = 8;
    parameter int unsigned CBR_SYNC_STAGES = 2;

    // Positions inside the synchronized input vector.
    localparam int unsigned SV_PHI1  = 0;
    localparam int unsigned SV_PHI2  = 1;
    localparam int unsigned SV_PHI3  = 2;
    localparam int unsigned SV_CPU   = 3;
    localparam int unsigned SV_MREF  = 4;
    localparam int unsigned SV_CREF  = 5;
    localparam int unsigned SV_CHAIN = 6;
    localparam int unsigned SV_WIDTH = 7;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WAIT = 2'd1,
        XS_OWN  = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/cbr_sync.sv
// Multi-stage synchronizer for a vector of slow asynchronous levels.
// Assumes: STAGES >= 1 and inputs are logical (active-high), so reset clears to 0.
module cbr_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // Shift the sampled levels one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/cbr_edges.sv
// One-clock edge pulses on synchronized levels; FALLING picks the edge kind.
// Assumes: inputs are already in the clk domain.
module cbr_edges #(
    parameter int unsigned WIDTH   = 1,
    parameter bit          FALLING = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] prev_q;

    // Remember the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    if (FALLING) begin : g_fall
        assign hit = prev_q & ~lvl;
    end else begin : g_rise
        assign hit = ~prev_q & lvl;
    end
endmodule

// File: rtl/cbr_arbiter.sv
// Per-cycle grant and chain forwarding for one peripheral slot.
// Assumes: every claim in above_s outranks the peripheral chain; grant is only
// consumed by the caller on the cycle-opening edge.
module cbr_arbiter #(
    parameter int unsigned N_ABOVE = 3
) (
    input  logic [N_ABOVE-1:0] above_s,
    input  logic               chain_up_s,
    input  logic               chain_up_raw,
    input  logic               want,
    input  logic               own,
    output logic               grant_ok,
    output logic               chain_fwd
);
    // Free only when no higher claimant and no upstream card is using the cycle.
    always_comb grant_ok = want & ~(|above_s) & ~chain_up_s;

    // Downstream request: pass upstream through, or announce our own cycle.
    always_comb chain_fwd = chain_up_raw | own;
endmodule

// File: rtl/cbr_xfer.sv
// Local transaction holder: accepts one request, waits for a granted cycle,
// owns it, captures read data and signals completion.
// Assumes: cyc_open, ph1_rise and ph2_fall are one-clock pulses in bus order.
module cbr_xfer
    import cbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              cyc_open,
    input  logic              grant_ok,
    input  logic              ph1_rise,
    input  logic              ph2_fall,
    input  logic [DATA_W-1:0] rd_bus,
    output logic              want,
    output logic              own,
    output logic              own_wr,
    output logic [ADDR_W-1:0] own_addr,
    output logic [DATA_W-1:0] own_wdata,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata
);
    xfer_state_e       state_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              armed_q;
    logic              done_q;

    // Sequence one request through wait, own and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                XS_IDLE: if (req_valid) begin
                    wr_q    <= req_write;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    state_q <= XS_WAIT;
                end
                XS_WAIT: if (cyc_open && grant_ok) state_q <= XS_OWN;
                XS_OWN: if (cyc_open) begin
                    state_q <= XS_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    // Arm read capture once phase 1 has been seen inside the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (cyc_open) armed_q <= 1'b0;
        else if (ph1_rise) armed_q <= 1'b1;
    end

    // Capture the read byte at the armed phase-2 falling edge of an owned read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state_q == XS_OWN && !wr_q && armed_q && ph2_fall) begin
            rdata_q <= rd_bus;
        end
    end

    assign req_ready  = (state_q == XS_IDLE);
    assign want       = (state_q == XS_WAIT);
    assign own        = (state_q == XS_OWN);
    assign own_wr     = wr_q;
    assign own_addr   = addr_q;
    assign own_wdata  = wdata_q;
    assign done       = done_q;
    assign done_rdata = rdata_q;
endmodule

// File: rtl/chain_bus_requester.sv
// Peripheral requester on a phase-framed shared memory bus with a priority
// daisy chain. Converts ground-true bus levels to logic, synchronizes the bus
// phases and claims, picks free cycles and drives one access per grant.
// Assumes: open-collector lines are modelled as enable plus level; the bus
// phases are much slower than clk.
module chain_bus_requester
    import cbr_pkg::*;
#(
    parameter int unsigned ADDR_W      = CBR_ADDR_W,
    parameter int unsigned DATA_W      = CBR_DATA_W,
    parameter int unsigned SYNC_STAGES = CBR_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi1,
    input  logic              phi2,
    input  logic              phi3,
    input  logic              cpu_claim_l,
    input  logic              mref_claim_l,
    input  logic              cref_claim_l,
    input  logic              chain_in_l,
    output logic              chain_out_oe,
    output logic              chain_out_lvl,
    output logic              addr_oe,
    output logic [ADDR_W-1:0] addr_lvl,
    output logic              rd_oe,
    output logic              rd_lvl,
    output logic              wr_oe,
    output logic              wr_lvl,
    input  logic [DATA_W-1:0] data_in_lvl,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out_lvl,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata
);
    localparam int unsigned N_ABOVE = SV_CHAIN - SV_CPU;

    logic [SV_WIDTH-1:0] raw_in;
    logic [SV_WIDTH-1:0] syn_in;
    logic [N_ABOVE-1:0]  higher_s;
    logic                chain_up_s;
    logic [1:0]          falls;
    logic                ph1_rise;
    logic                cyc_open;
    logic                ph2_fall;
    logic                grant_ok;
    logic                chain_fwd;
    logic                want;
    logic                own;
    logic                own_wr;
    logic [ADDR_W-1:0]   own_addr;
    logic [DATA_W-1:0]   own_wdata;

    // Gather phases and logical (inverted bus level) claims for synchronizing.
    always_comb begin
        raw_in           = '0;
        raw_in[SV_PHI1]  = phi1;
        raw_in[SV_PHI2]  = phi2;
        raw_in[SV_PHI3]  = phi3;
        raw_in[SV_CPU]   = ~cpu_claim_l;
        raw_in[SV_MREF]  = ~mref_claim_l;
        raw_in[SV_CREF]  = ~cref_claim_l;
        raw_in[SV_CHAIN] = ~chain_in_l;
    end

    cbr_sync #(.WIDTH(SV_WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    cbr_edges #(.WIDTH(2), .FALLING(1'b1)) u_fall (
        .clk(clk), .rst_n(rst_n), .lvl(syn_in[SV_PHI3:SV_PHI2]), .hit(falls)
    );

    cbr_edges #(.WIDTH(1), .FALLING(1'b0)) u_rise (
        .clk(clk), .rst_n(rst_n), .lvl(syn_in[SV_PHI1]), .hit(ph1_rise)
    );

    assign ph2_fall   = falls[0];
    assign cyc_open   = falls[1];
    assign higher_s   = syn_in[SV_CREF:SV_CPU];
    assign chain_up_s = syn_in[SV_CHAIN];

    cbr_arbiter #(.N_ABOVE(N_ABOVE)) u_arb (
        .above_s(higher_s), .chain_up_s(chain_up_s), .chain_up_raw(~chain_in_l),
        .want(want), .own(own), .grant_ok(grant_ok), .chain_fwd(chain_fwd)
    );

    cbr_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .cyc_open(cyc_open), .grant_ok(grant_ok), .ph1_rise(ph1_rise),
        .ph2_fall(ph2_fall), .rd_bus(~data_in_lvl),
        .want(want), .own(own), .own_wr(own_wr), .own_addr(own_addr),
        .own_wdata(own_wdata), .done(done), .done_rdata(done_rdata)
    );

    // Ground-true bus drive: asserted lines pull to 0, released lines read 1.
    always_comb begin
        chain_out_oe  = chain_fwd;
        chain_out_lvl = ~chain_fwd;
        addr_oe       = own;
        addr_lvl      = own ? ~own_addr : '1;
        rd_oe         = own & ~own_wr;
        rd_lvl        = ~(own & ~own_wr);
        wr_oe         = own & own_wr;
        wr_lvl        = ~(own & own_wr);
        data_oe       = own & own_wr;
        data_out_lvl  = (own & own_wr) ? ~own_wdata : '1;
    end
endmodule

// File: rtl/cbr_checker.sv
// Property checker for chain_bus_requester, attached by bind.
// Assumes: the bound signals use the names inside the top module.
module cbr_checker #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_open,
    input logic [2:0]        higher_s,
    input logic              chain_up_s,
    input logic              chain_in_l,
    input logic              chain_out_oe,
    input logic              addr_oe,
    input logic [ADDR_W-1:0] addr_lvl,
    input logic              rd_oe,
    input logic              wr_oe,
    input logic              data_oe,
    input logic              req_ready,
    input logic              done
);
    a_r2_open_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> $past(cyc_open));
    a_r2_close_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe) |-> $past(cyc_open));
    a_r3_rank_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> ($past(higher_s) == 3'b000));
    a_r4_upstream_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> !$past(chain_up_s));
    a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_in_l |-> chain_out_oe);
    a_r5_chain_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> chain_out_oe);
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> (rd_oe ^ wr_oe));
    a_r6_data_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (wr_oe && addr_oe));
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && $past(addr_oe)) |-> $stable(addr_lvl));
    a_r8_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> (addr_lvl == '1 && !rd_oe && !wr_oe && !data_oe));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_closes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(addr_oe) && !addr_oe));
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> !req_ready);
endmodule

bind chain_bus_requester cbr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_open(cyc_open), .higher_s(higher_s),
    .chain_up_s(chain_up_s), .chain_in_l(chain_in_l), .chain_out_oe(chain_out_oe),
    .addr_oe(addr_oe), .addr_lvl(addr_lvl), .rd_oe(rd_oe), .wr_oe(wr_oe),
    .data_oe(data_oe), .req_ready(req_ready), .done(done)
);

// File: tb/chain_bus_requester_test.sv
// Scoreboard bench: a bus model runs phase-framed cycles, a driver schedules
// requests and pushes expected completions; a monitor pops them on done.
module chain_bus_requester_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi1 = 1'b0, phi2 = 1'b0, phi3 = 1'b0;
    logic        cpu_claim_l = 1'b1, mref_claim_l = 1'b1, cref_claim_l = 1'b1;
    logic        chain_in_l = 1'b1;
    logic        chain_out_oe, chain_out_lvl, addr_oe, rd_oe, rd_lvl, wr_oe, wr_lvl;
    logic [15:0] addr_lvl;
    logic [7:0]  data_in_lvl = 8'hFF;
    logic        data_oe;
    logic [7:0]  data_out_lvl;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  done_rdata;

    always #2 clk = ~clk;

    chain_bus_requester uut (
        .clk(clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2), .phi3(phi3),
        .cpu_claim_l(cpu_claim_l), .mref_claim_l(mref_claim_l),
        .cref_claim_l(cref_claim_l), .chain_in_l(chain_in_l),
        .chain_out_oe(chain_out_oe), .chain_out_lvl(chain_out_lvl),
        .addr_oe(addr_oe), .addr_lvl(addr_lvl), .rd_oe(rd_oe), .rd_lvl(rd_lvl),
        .wr_oe(wr_oe), .wr_lvl(wr_lvl), .data_in_lvl(data_in_lvl),
        .data_oe(data_oe), .data_out_lvl(data_out_lvl),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .done_rdata(done_rdata)
    );

    typedef struct { logic wr; logic [7:0] rdata; } exp_t;
    exp_t exp_q[$];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Model state: 0 idle, 1 pending, 2 owning the current cycle.
    int          m_state = 0;
    logic        m_wr = 1'b0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [3:0]  cur_c = '0, pend_c = '0;   // {chain, cref, mref, cpu}
    bit          prev_own = 0;
    bit          iss_pend = 0;
    logic        iss_wr;
    logic [15:0] iss_addr;
    logic [7:0]  iss_wdata;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic schedule(input logic wr, input logic [15:0] a, input logic [7:0] d);
        iss_pend  = 1;
        iss_wr    = wr;
        iss_addr  = a;
        iss_wdata = d;
    endtask

    // One memory cycle of 16 clocks; nxt = claims for the following cycle.
    task automatic one_cycle(input logic [3:0] nxt);
        bit own;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            phi1 = (c >= 2 && c <= 4);
            phi2 = (c >= 6 && c <= 9);
            phi3 = (c >= 12);
            req_valid = 1'b0;
            if (c == 0) begin
                prev_own = (m_state == 2);
                cur_c = pend_c;
                if (m_state == 2) m_state = 0;
                else if (m_state == 1 && cur_c == 4'b0000) begin
                    m_state = 2;
                    exp_q.push_back('{m_wr, m_addr[7:0] ^ 8'h5A});
                end
            end
            if (c == 1) chk("R2 ownership kept until edge seen", addr_oe, prev_own);
            if (c == 4) data_in_lvl = 8'hFF;
            if (c == 6) begin
                own = (m_state == 2);
                chk("R5/R4 chain out enable", chain_out_oe, own || cur_c[3]);
                chk("R8 chain out level", chain_out_lvl, !(own || cur_c[3]));
                chk("R2/R3 address drive", addr_oe, own);
                chk("R8 address level", addr_lvl, own ? {16'h0, ~m_addr} : 32'hFFFF);
                chk("R6 read strobe", {rd_oe, rd_lvl}, (own && !m_wr) ? 2'b10 : 2'b01);
                chk("R6 write strobe", {wr_oe, wr_lvl}, (own && m_wr) ? 2'b10 : 2'b01);
                chk("R6 write data", {data_oe, data_out_lvl},
                    (own && m_wr) ? {1'b1, ~m_wdata} : {1'b0, 8'hFF});
                chk("R10 ready", req_ready, m_state == 0);
            end
            if (c == 7 && rd_oe && !rd_lvl) data_in_lvl = ~((~addr_lvl[7:0]) ^ 8'h5A);
            if (c == 8) begin
                cpu_claim_l  = ~nxt[0];
                mref_claim_l = ~nxt[1];
                cref_claim_l = ~nxt[2];
                chain_in_l   = ~nxt[3];
                pend_c = nxt;
            end
            if (c == 10 && iss_pend) begin
                req_valid = 1'b1;
                req_write = iss_wr;
                req_addr  = iss_addr;
                req_wdata = iss_wdata;
                if (m_state == 0) begin
                    m_state = 1;
                    m_wr    = iss_wr;
                    m_addr  = iss_addr;
                    m_wdata = iss_wdata;
                end
                iss_pend = 0;
            end
            if (c == 14) chk("R6 address held late in cycle", addr_oe, m_state == 2);
        end
    endtask

    task automatic run(input int n, input logic [3:0] c);
        for (int i = 0; i < n; i++) one_cycle(c);
    endtask

    // Monitor: pop one expectation per done pulse and compare.
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !finished) begin
            if (done) begin
                chk("R10 done one clock wide", done_prev, 1'b0);
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected done", 1'b1, 1'b0);
                end else begin
                    e = exp_q.pop_front();
                    if (!e.wr) chk("R7 read data returned", done_rdata, e.rdata);
                    else       chk("R10 write completion", done, 1'b1);
                end
            end
            done_prev = done;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset bus released", {chain_out_oe, addr_oe, rd_oe, wr_oe, data_oe}, 5'b0);
        chk("R1 reset levels high", {chain_out_lvl, addr_lvl, rd_lvl, wr_lvl, data_out_lvl},
            {1'b1, 16'hFFFF, 1'b1, 1'b1, 8'hFF});
        chk("R1 reset ready and done", {req_ready, done}, 2'b10);
        rst_n = 1'b1;
        run(2, 4'b0000);
        // R2 R5 R6 R8: write on a free bus.
        schedule(1'b1, 16'h3C81, 8'hA7);
        run(3, 4'b0000);
        // R7: read on a free bus.
        schedule(1'b0, 16'h1234, 8'h00);
        run(3, 4'b0000);
        // R3: each higher claimant blocks in turn, then a combined claim.
        schedule(1'b0, 16'hBEEF, 8'h00);
        run(1, 4'b0001);
        run(1, 4'b0010);
        run(1, 4'b0100);
        run(1, 4'b1001);
        run(3, 4'b0000);
        // R4: upstream request blocks and is passed through.
        schedule(1'b1, 16'h0F0F, 8'h5C);
        run(3, 4'b1000);
        run(3, 4'b0000);
        run(2, 4'b1000);
        run(2, 4'b0000);
        // R10: offers while pending or owning are dropped.
        schedule(1'b0, 16'h00AA, 8'h00);
        run(1, 4'b0001);
        schedule(1'b1, 16'hFFFF, 8'h11);
        run(1, 4'b0000);
        schedule(1'b1, 16'h7777, 8'h22);
        run(3, 4'b0000);
        // R9: pending across an 80-cycle character refresh run.
        schedule(1'b0, 16'h4D2E, 8'h00);
        run(80, 4'b0100);
        run(3, 4'b0000);
        // R7: another read pattern.
        schedule(1'b0, 16'h80C3, 8'h00);
        run(4, 4'b0000);
        chk("R10 every request completed once", exp_q.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule